// File: doc/BRIEF.md
# Subvector Element Swizzle Unit

This block rearranges the scalars of one short vector per operation. A source subvector of one to four scalars arrives packed on a wide bus. A list of per-slot source indices chooses, for each destination slot, which source scalar is copied into it. Indices may repeat or skip source elements. The source and destination lengths are set independently, so for example a three-wide vector can be widened to four with one component duplicated. The scalar width is chosen per operation: 8, 16, 32 or 64 bits.

The result leaves as a packed destination subvector together with a byte-granular write enable, which a register file uses to update only the bytes that belong to the active destination slots. The whole subvector counts as one element for masking, so a single predicate bit either lets the whole result be written or suppresses every enable. Operations enter through a valid/ready handshake at a rate of one per cycle. The result is held in a register and is presented one cycle after the operation is accepted.

Top module: `swz_unit`

## Requirements
- R1: `elem_w` selects the scalar width W as 2'b00=8, 2'b01=16, 2'b10=32 and 2'b11=64 bits. Source and destination are packed little-endian: element k occupies bits [k*W +: W].
- R2: For each destination slot i below the destination length, the slot receives the source element whose number is `sel_idx[2*i +: 2]`. Repeated indices copy the same source element into several slots.
- R3: A length code n means n+1 elements, for both `src_len` and `dst_len`. A slot whose index is greater than or equal to the source length is driven with zero.
- R4: Destination slots at or beyond the destination length are driven with zero, and their byte enables are cleared. Every bus bit above `(dst_len+1)*W` is therefore zero.
- R5: `lane_we` bit b enables byte b of `dst_data` (bits [8*b +: 8]). With the predicate set, exactly the bytes below `(dst_len+1)*W/8` are enabled.
- R6: When `pred` is 0, the operation is still accepted and `out_valid` still rises, but all bits of `lane_we` are 0.
- R7: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid`=1 after that edge. If no operation is accepted while the output drains, `out_valid` falls.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, `dst_data` and `lane_we` hold still and new input is not taken.
- R9: A synchronous active-high `rst` clears `out_valid`, `dst_data` and `lane_we` to 0, which leaves `in_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation this cycle |
| src_data | input | 256 | Packed source subvector |
| src_len | input | 2 | Source length code (n+1 elements) |
| dst_len | input | 2 | Destination length code (n+1 elements) |
| elem_w | input | 2 | Scalar width code |
| sel_idx | input | 8 | Four 2-bit source indices, slot 0 in the low bits |
| pred | input | 1 | Predicate bit for the whole subvector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| dst_data | output | 256 | Packed destination subvector |
| lane_we | output | 32 | Byte write enables for dst_data |

## Verification
The situation hardest to reach from the ports is a stall that overlaps a pending operation. In that case the held result must stay frozen while a different operation waits on the input, and the waiting operation must be taken on the exact cycle the consumer releases the output. The stimulus holds `out_ready` low, raises `in_valid` with a second, distinguishable operation for several cycles, and then releases the output. It checks that the first result never changed and that the second one follows on the next cycle. Out-of-range indices and short destinations are reached through table rows that place index values at and above the source length at every scalar width.

// File: rtl/swz_pkg.sv
package swz_pkg;

  // Scalar width selector
  typedef enum logic [1:0] {
    SWZ_W8  = 2'b00,
    SWZ_W16 = 2'b01,
    SWZ_W32 = 2'b10,
    SWZ_W64 = 2'b11
  } swz_width_e;

  localparam int SWZ_MIN_ELEM_W = 8;

  // Width in bits selected by a width code
  function automatic int swz_bits(input swz_width_e code);
    return SWZ_MIN_ELEM_W << int'(code);
  endfunction

endpackage

// File: rtl/swz_select.sv
// Picks one source scalar for one destination slot, for every supported
// width at once, then keeps the variant named by the width code.
module swz_select
  import swz_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int ELEM_MAX_W = 64,
  localparam int IDX_W     = $clog2(SLOTS),
  localparam int DW        = SLOTS * ELEM_MAX_W,
  localparam int NW        = $clog2(ELEM_MAX_W / SWZ_MIN_ELEM_W) + 1
) (
  input  logic [DW-1:0]         src_data,
  input  logic [IDX_W-1:0]      src_len,
  input  logic [IDX_W-1:0]      idx,
  input  swz_width_e            ew,
  output logic [ELEM_MAX_W-1:0] slot_val
);

  logic [ELEM_MAX_W-1:0] cand [NW];

  for (genvar gw = 0; gw < NW; gw++) begin : g_width
    localparam int W = SWZ_MIN_ELEM_W << gw;
    logic [W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int j = 0; j < SLOTS; j++) begin
        if (idx == IDX_W'(j)) pick = src_data[j*W +: W];
      end
    end
    assign cand[gw] = ELEM_MAX_W'(pick);
  end

  // Index past the source length yields zero
  always_comb begin
    if (idx <= src_len) slot_val = cand[int'(ew)];
    else                slot_val = '0;
  end

endmodule

// File: rtl/swz_pack.sv
// Packs slot values at the selected width, zeroes inactive slots and
// forms the byte enables.
module swz_pack
  import swz_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int ELEM_MAX_W = 64,
  localparam int IDX_W     = $clog2(SLOTS),
  localparam int DW        = SLOTS * ELEM_MAX_W,
  localparam int BYTES     = DW / 8,
  localparam int NW        = $clog2(ELEM_MAX_W / SWZ_MIN_ELEM_W) + 1
) (
  input  logic [ELEM_MAX_W-1:0] slot_val [SLOTS],
  input  logic [IDX_W-1:0]      dst_len,
  input  swz_width_e            ew,
  input  logic                  pred,
  output logic [DW-1:0]         packed_data,
  output logic [BYTES-1:0]      byte_en
);

  logic [DW-1:0]    pk_w [NW];
  logic [BYTES-1:0] be_w [NW];

  for (genvar gw = 0; gw < NW; gw++) begin : g_width
    localparam int W  = SWZ_MIN_ELEM_W << gw;
    localparam int WB = W / 8;
    always_comb begin
      pk_w[gw] = '0;
      for (int i = 0; i < SLOTS; i++) begin
        if (IDX_W'(i) <= dst_len) pk_w[gw][i*W +: W] = slot_val[i][W-1:0];
      end
    end
    always_comb begin
      be_w[gw] = '0;
      for (int b = 0; b < BYTES; b++) begin
        if (b < (int'(dst_len) + 1) * WB) be_w[gw][b] = 1'b1;
      end
    end
  end

  assign packed_data = pk_w[int'(ew)];
  assign byte_en     = pred ? be_w[int'(ew)] : '0;

endmodule

// File: rtl/swz_out_stage.sv
// Result register with a valid/ready handshake.
module swz_out_stage #(
  parameter int DW    = 256,
  parameter int BYTES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    d_in,
  input  logic [BYTES-1:0] be_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    d_out,
  output logic [BYTES-1:0] be_out
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      d_out     <= '0;
      be_out    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        d_out  <= d_in;
        be_out <= be_in;
      end
    end
  end

  // R7: an accepted operation is presented on the next cycle
  p_valid_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8: a stalled result is frozen
  p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(d_out) && $stable(be_out)));

endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int ELEM_MAX_W = 64,
  localparam int IDX_W     = $clog2(SLOTS),
  localparam int DW        = SLOTS * ELEM_MAX_W,
  localparam int BYTES     = DW / 8,
  localparam int MAX_EB    = ELEM_MAX_W / 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DW-1:0]          src_data,
  input  logic [IDX_W-1:0]       src_len,
  input  logic [IDX_W-1:0]       dst_len,
  input  logic [1:0]             elem_w,
  input  logic [SLOTS*IDX_W-1:0] sel_idx,
  input  logic                   pred,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DW-1:0]          dst_data,
  output logic [BYTES-1:0]       lane_we
);

  swz_width_e            ew;
  logic [ELEM_MAX_W-1:0] slot_val [SLOTS];
  logic [DW-1:0]         packed_data;
  logic [BYTES-1:0]      byte_en;

  assign ew = swz_width_e'(elem_w);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    swz_select #(.SLOTS(SLOTS), .ELEM_MAX_W(ELEM_MAX_W)) u_sel (
      .src_data (src_data),
      .src_len  (src_len),
      .idx      (sel_idx[s*IDX_W +: IDX_W]),
      .ew       (ew),
      .slot_val (slot_val[s])
    );
  end

  swz_pack #(.SLOTS(SLOTS), .ELEM_MAX_W(ELEM_MAX_W)) u_pack (
    .slot_val    (slot_val),
    .dst_len     (dst_len),
    .ew          (ew),
    .pred        (pred),
    .packed_data (packed_data),
    .byte_en     (byte_en)
  );

  swz_out_stage #(.DW(DW), .BYTES(BYTES)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_in      (packed_data),
    .be_in     (byte_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .d_out     (dst_data),
    .be_out    (lane_we)
  );

  // R6: a masked operation writes nothing
  p_pred_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !pred) |=> (out_valid && lane_we == '0));

  // R3: slot 0 with an out-of-range index yields a zero low byte
  p_oob_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && sel_idx[IDX_W-1:0] > src_len) |=> (dst_data[7:0] == 8'h00));

  // R4: a one-slot destination enables nothing past the widest scalar
  p_short_dst_we_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && dst_len == '0) |=> (lane_we[BYTES-1:MAX_EB] == '0));

  // R9: no result is presented while reset is held
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/swz_unit_bench.sv
module swz_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [7:0]  seed;
    logic [1:0]  sl;
    logic [1:0]  dl;
    logic [1:0]  ew;
    logic [7:0]  idx;
    logic        pred;
    logic [31:0] we;
  } vec_t;

  // seed, src_len, dst_len, width, indices, pred, expected byte enables
  localparam vec_t VECS [NVEC] = '{
    '{8'h10, 2'd2, 2'd3, 2'd0, 8'h60, 1'b1, 32'h0000000F}, // 3->4 dup [0,0,2,1], 8b
    '{8'h21, 2'd3, 2'd1, 2'd1, 8'h07, 1'b1, 32'h0000000F}, // 16b, [3,1]
    '{8'h32, 2'd1, 2'd3, 2'd2, 8'h9C, 1'b1, 32'h0000FFFF}, // 32b, oob slots 1,3
    '{8'h43, 2'd3, 2'd3, 2'd3, 8'h1B, 1'b1, 32'hFFFFFFFF}, // 64b reverse
    '{8'h54, 2'd0, 2'd0, 2'd0, 8'h00, 1'b1, 32'h00000001}, // single 8b
    '{8'h65, 2'd0, 2'd2, 2'd3, 8'h01, 1'b1, 32'h00FFFFFF}, // 64b, slot0 oob
    '{8'h76, 2'd3, 2'd3, 2'd2, 8'hE4, 1'b0, 32'h00000000}, // predicate off
    '{8'h87, 2'd2, 2'd2, 2'd1, 8'h2A, 1'b1, 32'h0000003F}  // 16b broadcast
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] src_data = '0;
  logic [1:0]   src_len = '0;
  logic [1:0]   dst_len = '0;
  logic [1:0]   elem_w = '0;
  logic [7:0]   sel_idx = '0;
  logic         pred = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] dst_data;
  logic [31:0]  lane_we;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swz_unit u_swz_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_data(src_data), .src_len(src_len), .dst_len(dst_len),
    .elem_w(elem_w), .sel_idx(sel_idx), .pred(pred),
    .out_valid(out_valid), .out_ready(out_ready),
    .dst_data(dst_data), .lane_we(lane_we)
  );

  function automatic logic [255:0] mk_src(input logic [7:0] seed);
    logic [255:0] s;
    for (int b = 0; b < 32; b++) s[8*b +: 8] = seed + 8'(b * 8'h0B);
    return s;
  endfunction

  // Expected packed result from R1..R4
  function automatic logic [255:0] ref_data(input logic [255:0] s, input logic [1:0] sl,
                                            input logic [1:0] dl, input logic [1:0] ew,
                                            input logic [7:0] ix);
    logic [255:0] r;
    int w;
    int j;
    r = '0;
    w = 8 << ew;
    for (int i = 0; i < 4; i++) begin
      if (i <= int'(dl)) begin
        j = int'(ix[2*i +: 2]);
        if (j <= int'(sl))
          for (int b = 0; b < w; b++) r[i*w + b] = s[j*w + b];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src_data = mk_src(v.seed);
    src_len  = v.sl;
    dst_len  = v.dl;
    elem_w   = v.ew;
    sel_idx  = v.idx;
    pred     = v.pred;
    in_valid = 1'b1;
  endtask

  task automatic check_result(input string tag, input vec_t v);
    chk({tag, " R7 out_valid"}, 256'(out_valid), 256'(1));
    chk({tag, " R5 lane_we"}, 256'(lane_we), 256'(v.we));
    if (v.pred)
      chk({tag, " R2 dst_data"}, dst_data,
          ref_data(mk_src(v.seed), v.sl, v.dl, v.ew, v.idx));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", 256'(out_valid), 256'(0));
    chk("R9 lane_we", 256'(lane_we), 256'(0));
    chk("R9 dst_data", dst_data, 256'(0));
    chk("R9 in_ready", 256'(in_ready), 256'(1));
    rst = 1'b0;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      in_valid = 1'b0;
      check_result($sformatf("vec%0d", k), VECS[k]);
      @(negedge clk);
    end

    // R6: masked operation is consumed and the unit stays ready
    chk("R6 in_ready after mask", 256'(in_ready), 256'(1));

    // R7: back-to-back operations, one per cycle
    drive(VECS[0]);
    @(negedge clk);
    check_result("b2b0", VECS[0]);
    drive(VECS[3]);
    @(negedge clk);
    in_valid = 1'b0;
    check_result("b2b1", VECS[3]);
    @(negedge clk);
    chk("R7 drain", 256'(out_valid), 256'(0));

    // R8: stall with a second operation waiting
    out_ready = 1'b0;
    drive(VECS[2]);
    @(negedge clk);
    drive(VECS[5]);
    check_result("stall0", VECS[2]);
    chk("R8 in_ready low", 256'(in_ready), 256'(0));
    repeat (3) @(negedge clk);
    check_result("stall_hold", VECS[2]);
    chk("R8 in_ready still low", 256'(in_ready), 256'(0));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result("after_stall", VECS[5]);
    @(negedge clk);
    chk("R7 idle after drain", 256'(out_valid), 256'(0));

    // R4: 8-bit, dst of one slot from a wide source, upper bus must be zero
    drive('{8'h9A, 2'd3, 2'd0, 2'd0, 8'hFF, 1'b1, 32'h00000001});
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 upper zero", dst_data >> 8, 256'(0));
    chk("R3 R1 slot0 byte", 256'(dst_data[7:0]), 256'(mk_src(8'h9A) >> 24) & 256'hFF);
    chk("R4 lane_we", 256'(lane_we), 256'(1));

    // R9: reset while a result is held
    out_ready = 1'b0;
    drive(VECS[3]);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 mid reset valid", 256'(out_valid), 256'(0));
    chk("R9 mid reset data", dst_data, 256'(0));
    chk("R9 mid reset we", 256'(lane_we), 256'(0));
    out_ready = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule